// File: doc/BRIEF.md
# Video capture window writer

This block takes a stream of pixel words and stores them into a rectangle of frame-buffer memory, much like a rectangle copy whose source is a capture port instead of memory. Software sets four window values (start address, width in words, height in lines, line stride) and a source selector. A vertical sync starts a capture at the start address. Each accepted word is written to the next address. A horizontal sync moves the write pointer to the start of the next line, which lies one stride further on.

A line ends on a horizontal sync or when its width count is used up, whichever comes first. A window ends on a vertical sync or after its height count of lines, whichever comes first. The source selector picks full 16-bit port words, 8-bit port bytes packed in pairs, or words supplied by the processor. Writes leave the block as a single request held until the memory side acknowledges it. A word that arrives while a request is still waiting is lost, and a sticky flag records the loss.

Top module: `vcap_window_writer`

## Requirements
- R1: A cycle with `vs` high copies the window settings and starts a capture at `cfg_start`. `busy` goes high when the mode is valid and the height is non-zero.
- R2: In mode 3'b001 each accepted `pix_data` word is written unchanged. Successive words go to successive addresses (+1).
- R3: `hs` during a capture that is not on its last line moves the write address to the previous line base plus `cfg_stride` and resets the word count.
- R4: Words beyond the width count on a line are not written and do not move the address until the next `hs`.
- R5: The capture ends after the last line's width count is written or on `hs` during the last line. `busy` then drops, and later words are ignored until `vs`.
- R6: After reset `wr_req`, `ovf_flag` and `busy` are 0, and input words produce no write until a `vs`.
- R7: In mode 3'b010 only `pix_data[7:0]` is used. The first byte of a pair becomes bits 7:0 of the written word and the second byte becomes bits 15:8. The pairing restarts at every `vs` and `hs`.
- R8: In mode 3'b100 the word source is `cpu_valid`/`cpu_data` and the port is ignored. Any mode code other than 001, 010 or 100 writes nothing.
- R9: Changes to the settings after `vs` do not affect the running window. They take effect at the next `vs`.
- R10: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` hold their values.
- R11: A word that arrives while a request waits without an acknowledge is dropped without moving the address, and it sets `ovf_flag`. The flag stays set until `ovf_clear` is pulsed.
- R12: A `vs` during a capture restarts it at the start address. A width of 0 or a height of 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; port samples are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Source selector: 001 port16, 010 port8, 100 processor |
| cfg_start | input | ADDR_W | Window start word address |
| cfg_width | input | DIM_W | Words per line |
| cfg_height | input | DIM_W | Lines per window |
| cfg_stride | input | ADDR_W | Address step between line bases |
| ovf_clear | input | 1 | Clears the overflow flag |
| pix_valid | input | 1 | Port sample strobe |
| pix_data | input | DATA_W | Port sample |
| hs | input | 1 | Line sync pulse |
| vs | input | 1 | Frame sync pulse |
| cpu_valid | input | 1 | Processor word strobe |
| cpu_data | input | DATA_W | Processor word |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Memory accepts the request in this cycle |
| ovf_flag | output | 1 | Sticky dropped-word flag |
| busy | output | 1 | Capture window active |

## Verification
The checks assume that `hs` and `vs` are single-cycle pulses synchronous to `clk` that never arrive together. They also assume that a data strobe arriving in a sync cycle may be discarded. The bench drives every sync as one isolated cycle and places data strobes only in other cycles. The overflow check assumes the memory side drops `wr_ack` only while a request is visible. The bench holds `wr_ack` constant around each request and changes it only between requests, or while one request is deliberately left waiting.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam logic [2:0] MODE_PORT16 = 3'b001;
  localparam logic [2:0] MODE_PORT8  = 3'b010;
  localparam logic [2:0] MODE_CPU    = 3'b100;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m == MODE_PORT16) || (m == MODE_PORT8) || (m == MODE_CPU);
  endfunction
endpackage

// File: rtl/vcap_word_src.sv
module vcap_word_src
  import vcap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              flush,
  input  logic              port_valid,
  input  logic [DATA_W-1:0] port_data,
  input  logic              cpu_valid,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              word_valid,
  output logic [DATA_W-1:0] word
);
  localparam int HALF_W = DATA_W / 2;

  logic              phase_q, phase_d;
  logic [HALF_W-1:0] low_q, low_d;

  always_comb begin
    phase_d = phase_q;
    low_d   = low_q;
    if (flush) begin
      phase_d = 1'b0;
    end else if (mode == MODE_PORT8 && port_valid) begin
      if (!phase_q) begin
        low_d   = port_data[HALF_W-1:0];
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else begin
      phase_q <= phase_d;
      low_q   <= low_d;
    end
  end

  always_comb begin
    case (mode)
      MODE_PORT16: begin
        word_valid = port_valid;
        word       = port_data;
      end
      MODE_PORT8: begin
        word_valid = port_valid && phase_q;
        word       = {port_data[HALF_W-1:0], low_q};
      end
      MODE_CPU: begin
        word_valid = cpu_valid;
        word       = cpu_data;
      end
      default: begin
        word_valid = 1'b0;
        word       = '0;
      end
    endcase
  end
endmodule

// File: rtl/vcap_addr_gen.sv
module vcap_addr_gen
  import vcap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs,
  input  logic              hs,
  input  logic              word_valid,
  input  logic              can_issue,
  input  logic [2:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [ADDR_W-1:0] cfg_stride,
  output logic              active,
  output logic              take,
  output logic              drop_busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [2:0]        act_mode
);
  logic              active_q, active_d;
  logic [ADDR_W-1:0] line_q, line_d, addr_q, addr_d, stride_q, stride_d;
  logic [DIM_W-1:0]  col_q, col_d, row_q, row_d, width_q, width_d, height_q, height_d;
  logic [2:0]        mode_q, mode_d;
  logic              room, last_row, cand;

  assign room      = col_q < width_q;
  assign last_row  = row_q == height_q - 1'b1;
  assign cand      = active_q && word_valid && !vs && !hs && room;
  assign take      = cand && can_issue;
  assign drop_busy = cand && !can_issue;

  always_comb begin
    active_d = active_q;
    line_d   = line_q;
    addr_d   = addr_q;
    col_d    = col_q;
    row_d    = row_q;
    width_d  = width_q;
    height_d = height_q;
    stride_d = stride_q;
    mode_d   = mode_q;
    if (vs) begin
      width_d  = cfg_width;
      height_d = cfg_height;
      stride_d = cfg_stride;
      mode_d   = cfg_mode;
      line_d   = cfg_start;
      addr_d   = cfg_start;
      col_d    = '0;
      row_d    = '0;
      active_d = mode_ok(cfg_mode) && (cfg_height != '0);
    end else if (active_q && hs) begin
      if (last_row) begin
        active_d = 1'b0;
      end else begin
        row_d  = row_q + 1'b1;
        line_d = line_q + stride_q;
        addr_d = line_q + stride_q;
        col_d  = '0;
      end
    end else if (take) begin
      addr_d = addr_q + 1'b1;
      col_d  = col_q + 1'b1;
      if (col_q == width_q - 1'b1 && last_row) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      line_q   <= '0;
      addr_q   <= '0;
      col_q    <= '0;
      row_q    <= '0;
      width_q  <= '0;
      height_q <= '0;
      stride_q <= '0;
      mode_q   <= '0;
    end else begin
      active_q <= active_d;
      line_q   <= line_d;
      addr_q   <= addr_d;
      col_q    <= col_d;
      row_q    <= row_d;
      width_q  <= width_d;
      height_q <= height_d;
      stride_q <= stride_d;
      mode_q   <= mode_d;
    end
  end

  assign active   = active_q;
  assign cur_addr = addr_q;
  assign act_mode = mode_q;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> addr_q == $past(addr_q) + 1'b1);
  // R4
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> col_q <= width_q);
  // R5
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> row_q < height_q);
endmodule

// File: rtl/vcap_wr_port.sv
module vcap_wr_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              drop,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_ack,
  input  logic              ovf_clear,
  output logic              can_issue,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ovf_flag
);
  logic              req_q, req_d, ovf_q, ovf_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign can_issue = !req_q || wr_ack;

  always_comb begin
    req_d = req_q;
    if (take) req_d = 1'b1;
    else if (wr_ack) req_d = 1'b0;
    ovf_d = ovf_q;
    if (drop) ovf_d = 1'b1;
    else if (ovf_clear) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      req_q <= req_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= addr;
      data_q <= data;
    end
  end

  assign wr_req   = req_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign ovf_flag = ovf_q;

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !wr_ack) |=> (req_q && $stable(addr_q) && $stable(data_q)));
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
endmodule

// File: rtl/vcap_window_writer.sv
module vcap_window_writer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              ovf_clear,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              hs,
  input  logic              vs,
  input  logic              cpu_valid,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              ovf_flag,
  output logic              busy
);
  logic              active, take, drop_busy, can_issue, word_valid, flush;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] word;
  logic [2:0]        act_mode;

  assign flush = vs || hs || !active;
  assign busy  = active;

  vcap_word_src #(.DATA_W(DATA_W)) i_src (
    .clk(clk), .rst_n(rst_n), .mode(act_mode), .flush(flush),
    .port_valid(pix_valid), .port_data(pix_data),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data),
    .word_valid(word_valid), .word(word)
  );

  vcap_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_addr (
    .clk(clk), .rst_n(rst_n), .vs(vs), .hs(hs),
    .word_valid(word_valid), .can_issue(can_issue),
    .cfg_mode(cfg_mode), .cfg_start(cfg_start), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_stride(cfg_stride),
    .active(active), .take(take), .drop_busy(drop_busy),
    .cur_addr(cur_addr), .act_mode(act_mode)
  );

  vcap_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk(clk), .rst_n(rst_n), .take(take), .drop(drop_busy),
    .addr(cur_addr), .data(word), .wr_ack(wr_ack), .ovf_clear(ovf_clear),
    .can_issue(can_issue), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .ovf_flag(ovf_flag)
  );

  // R6
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !vs) |=> !(wr_req && !$past(wr_req)));
endmodule

// File: tb/test_vcap_window_writer.sv
`timescale 1ns/1ps
module test_vcap_window_writer;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int DIM_W  = 12;
  localparam int NCASE  = 7;

  // mode, start, width, height, stride, words per line, lines driven
  localparam int T_MODE  [NCASE] = '{1, 1, 1, 2, 4, 1, 3};
  localparam int T_START [NCASE] = '{'h100, 'h200, 'h300, 'h400, 'h500, 'h600, 'h700};
  localparam int T_WIDTH [NCASE] = '{4, 3, 6, 2, 3, 0, 2};
  localparam int T_HEIGHT[NCASE] = '{3, 2, 3, 2, 2, 2, 2};
  localparam int T_STRIDE[NCASE] = '{16, 8, 10, 4, 3, 8, 8};
  localparam int T_WPL   [NCASE] = '{4, 5, 2, 3, 3, 2, 2};
  localparam int T_LINES [NCASE] = '{3, 4, 3, 2, 2, 2, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [ADDR_W-1:0] cfg_start = '0, cfg_stride = '0;
  logic [DIM_W-1:0] cfg_width = '0, cfg_height = '0;
  logic ovf_clear = 0, pix_valid = 0, hs = 0, vs = 0, cpu_valid = 0, wr_ack = 1;
  logic [DATA_W-1:0] pix_data = '0, cpu_data = '0;
  logic wr_req, ovf_flag, busy;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  int checks = 0, errors = 0, q_wr = 0, q_rd = 0;
  logic [ADDR_W-1:0] q_addr [0:511];
  logic [DATA_W-1:0] q_data [0:511];

  always #2.5 clk = ~clk;

  vcap_window_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W)) i_vcap_window_writer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start(cfg_start),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_stride(cfg_stride),
    .ovf_clear(ovf_clear), .pix_valid(pix_valid), .pix_data(pix_data),
    .hs(hs), .vs(vs), .cpu_valid(cpu_valid), .cpu_data(cpu_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .ovf_flag(ovf_flag), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int a, input logic [DATA_W-1:0] d);
    q_addr[q_wr] = a[ADDR_W-1:0];
    q_data[q_wr] = d;
    q_wr++;
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_req && wr_ack) begin
      if (q_rd == q_wr) begin
        check(1'b0, "R6", "unexpected write addr", 32'(wr_addr), 32'hFFFFFFFF);
      end else begin
        check(wr_addr == q_addr[q_rd], "R2", "write address", 32'(wr_addr), 32'(q_addr[q_rd]));
        check(wr_data == q_data[q_rd], "R2", "write data", 32'(wr_data), 32'(q_data[q_rd]));
        q_rd++;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_vs();
    vs = 1; step(); vs = 0;
  endtask

  task automatic pulse_hs();
    hs = 1; step(); hs = 0;
  endtask

  task automatic send_port(input logic [DATA_W-1:0] d);
    pix_valid = 1; pix_data = d; step(); pix_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_case(input int k);
    bit ok_mode;
    ok_mode = (T_MODE[k] == 1) || (T_MODE[k] == 2) || (T_MODE[k] == 4);
    cfg_mode = 3'(T_MODE[k]); cfg_start = ADDR_W'(T_START[k]);
    cfg_width = DIM_W'(T_WIDTH[k]); cfg_height = DIM_W'(T_HEIGHT[k]);
    cfg_stride = ADDR_W'(T_STRIDE[k]);
    pulse_vs();
    // R1
    check(busy == (ok_mode && T_HEIGHT[k] != 0), "R1", "busy after vs", 32'(busy), 32'(ok_mode));
    for (int l = 0; l < T_LINES[k]; l++) begin
      for (int w = 0; w < T_WPL[k]; w++) begin
        logic [DATA_W-1:0] d;
        d = DATA_W'(16'h1000 * (k + 1) + l * 16 + w);
        if (ok_mode && l < T_HEIGHT[k] && w < T_WIDTH[k])
          push(T_START[k] + l * T_STRIDE[k] + w, d);   // R3 R4 R5
        if (T_MODE[k] == 2) begin                        // R7
          send_port({8'h5A, d[7:0]});
          send_port({8'hA5, d[15:8]});
        end else if (T_MODE[k] == 4) begin               // R8
          cpu_valid = 1; cpu_data = d; pix_valid = 1; pix_data = ~d;
          step();
          cpu_valid = 0; pix_valid = 0;
        end else begin
          send_port(d);
        end
      end
      pulse_hs();
    end
    idle(3);
    check(q_rd == q_wr, "R5", "pending expected writes", 32'(q_wr - q_rd), 0);
    check(busy == 1'b0, "R5", "busy after window", 32'(busy), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    check(1'b0, "R6", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1;
    step();
    // R6: reset state and input before any vs
    check(wr_req == 0, "R6", "wr_req after reset", 32'(wr_req), 0);
    check(ovf_flag == 0, "R6", "ovf_flag after reset", 32'(ovf_flag), 0);
    check(busy == 0, "R6", "busy after reset", 32'(busy), 0);
    cfg_mode = 3'b001; cfg_width = 4; cfg_height = 2;
    send_port(16'hDEAD); send_port(16'hBEEF); pulse_hs(); send_port(16'h1234);
    idle(3);
    check(q_rd == 0, "R6", "writes before vs", 32'(q_rd), 0);

    for (int k = 0; k < NCASE; k++) run_case(k);

    // R9 shadowing, R12 restart
    cfg_mode = 3'b001; cfg_start = 'h800; cfg_width = 4; cfg_height = 2; cfg_stride = 'h20;
    pulse_vs();
    push('h800, 16'hC000); send_port(16'hC000);
    push('h801, 16'hC001); send_port(16'hC001);
    cfg_start = 'hF00; cfg_stride = 1; cfg_width = 1;
    push('h802, 16'hC002); send_port(16'hC002);   // R9
    pulse_hs();
    push('h820, 16'hC003); send_port(16'hC003);   // R9
    pulse_vs();                                    // R12
    push('hF00, 16'hC004); send_port(16'hC004);
    send_port(16'hC005);
    check(busy == 1, "R12", "busy after restart", 32'(busy), 1);
    pulse_hs();
    push('hF01, 16'hC006); send_port(16'hC006);
    check(busy == 0, "R5", "busy after width end on last line", 32'(busy), 0);
    send_port(16'hC007);
    idle(3);
    check(q_rd == q_wr, "R9", "pending expected writes", 32'(q_wr - q_rd), 0);

    // R11 overflow, R10 hold
    wr_ack = 0;
    cfg_start = 'h40; cfg_width = 4; cfg_height = 1; cfg_stride = 0;
    pulse_vs();
    push('h40, 16'hE000); send_port(16'hE000);
    send_port(16'hE001);
    check(ovf_flag == 1, "R11", "flag after drop", 32'(ovf_flag), 1);
    step();
    check(wr_req == 1 && wr_addr == 'h40, "R10", "held request addr", 32'(wr_addr), 32'h40);
    check(wr_data == 16'hE000, "R10", "held request data", 32'(wr_data), 32'hE000);
    wr_ack = 1;
    step();
    push('h41, 16'hE002); send_port(16'hE002);   // R11: dropped word did not advance
    idle(3);
    check(ovf_flag == 1, "R11", "flag sticky", 32'(ovf_flag), 1);
    ovf_clear = 1; step(); ovf_clear = 0;
    check(ovf_flag == 0, "R11", "flag cleared", 32'(ovf_flag), 0);
    check(q_rd == q_wr, "R11", "pending expected writes", 32'(q_wr - q_rd), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule